// File: doc/BRIEF.md
# Sector Field Framer

This block produces and checks the byte-level layout of one disk sector. The write path turns a host byte stream into a track byte stream. It emits a zero gap, a sync byte, a four-byte identifier field and its CRC, then a second zero gap, a data sync byte, the sector payload and its CRC. A data-only write starts at the second gap, so the identifier on the medium is left alone. The data sync byte is 0xDD for special sectors and 0xDB for normal ones.

The read path takes a track byte stream and hunts for a sync byte inside a bounded window. It captures the identifier, checks both CRCs, and forwards the payload bytes to a consumer. Each outcome is reported on its own one-cycle strobe: identifier accepted, identifier sync missing, identifier CRC bad, data sync missing, data CRC bad, and a final done. The read path also shows whether the sector is defective and whether it holds special data. Each side moves bytes with a valid/ready handshake. The payload length comes from a two-bit size code, sampled when an operation starts.

Top module: `sector_framer`

## Requirements
- R1: After `wr_start` with `wr_with_id`=1, the line stream is exactly GAP_LEN (15) bytes 0x00, 0xDB, the four identifier bytes from the host (flag, cylinder, head, sector), two CRC bytes, GAP_LEN bytes 0x00, the data sync byte, the payload bytes, and two CRC bytes. `wr_busy` is low once the last CRC byte has been taken.
- R2: Each CRC uses polynomial 0x1021 with the register preset to 0xFFFF. Bits are fed most significant first, over the field's sync byte and all of its bytes. The high CRC byte is sent first, so a correctly framed field followed by its CRC leaves a remainder of zero.
- R3: The data sync byte is 0xDD when `wr_special` is set at start, otherwise 0xDB. On read, a 0xDD data sync sets `rd_special` and a 0xDB sync clears it. Only 0xDB is accepted as an identifier sync.
- R4: With `wr_with_id`=0, the line stream holds only the second gap, the data sync byte, the payload and its CRC.
- R5: The payload length is 128 bytes for `cfg_size` 0, 256 for 1, and 512 for 2 or 3. The size code is sampled in the start cycle, and later changes have no effect on the running operation.
- R6: After a good identifier CRC, `rd_id_ok` pulses for one cycle. `rd_id_flag`, `rd_id_cyl`, `rd_id_head` and `rd_id_sec` then hold the captured bytes, and `rd_defective` equals bit 0 of the flag byte.
- R7: When hunting for the identifier sync, a 0xDB is accepted at any of the first GAP_LEN+SYNC_TOL (19) byte positions. If all 19 bytes pass without one, `rd_id_sync_err` and `rd_done` pulse and the read ends.
- R8: The data sync is hunted the same way, starting right after the identifier CRC (or at start for a data-only read). If it is missing, `rd_data_sync_err` and `rd_done` pulse and no payload is forwarded.
- R9: A nonzero remainder after the identifier CRC pulses `rd_id_crc_err` and `rd_done`. The read then ends without a data phase.
- R10: A nonzero remainder after the data CRC pulses `rd_data_crc_err` together with `rd_done`. At most one error strobe is ever high in a cycle.
- R11: A byte moves only when valid and ready are both high. In the read payload phase, `line_in_ready` follows `rd_out_ready`, and every payload byte appears on `rd_out_data` in order.
- R12: While a path is busy, its start pulse and start-time controls are ignored. While the write path is idle, `line_out_valid` and `wr_in_ready` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size | input | 2 | Payload size code, sampled at start |
| wr_start | input | 1 | Starts a write framing run |
| wr_with_id | input | 1 | 1: also emit the identifier field |
| wr_special | input | 1 | 1: use the special data sync byte |
| wr_busy | output | 1 | Write path active |
| wr_in_valid | input | 1 | Host byte valid |
| wr_in_ready | output | 1 | Host byte taken |
| wr_in_data | input | 8 | Host byte (identifier bytes, then payload) |
| line_out_valid | output | 1 | Track byte valid |
| line_out_ready | input | 1 | Track sink ready |
| line_out_data | output | 8 | Track byte |
| rd_start | input | 1 | Starts a read run |
| rd_with_id | input | 1 | 1: expect the identifier field first |
| rd_busy | output | 1 | Read path active |
| line_in_valid | input | 1 | Track byte valid |
| line_in_ready | output | 1 | Track byte taken |
| line_in_data | input | 8 | Track byte |
| rd_out_valid | output | 1 | Payload byte valid |
| rd_out_ready | input | 1 | Payload consumer ready |
| rd_out_data | output | 8 | Payload byte |
| rd_id_flag | output | 8 | Captured flag byte |
| rd_id_cyl | output | 8 | Captured cylinder byte |
| rd_id_head | output | 8 | Captured head byte |
| rd_id_sec | output | 8 | Captured sector byte |
| rd_defective | output | 1 | Bit 0 of the captured flag |
| rd_special | output | 1 | Data sync was 0xDD |
| rd_id_ok | output | 1 | Strobe: identifier CRC good |
| rd_id_sync_err | output | 1 | Strobe: identifier sync not found |
| rd_id_crc_err | output | 1 | Strobe: identifier CRC bad |
| rd_data_sync_err | output | 1 | Strobe: data sync not found |
| rd_data_crc_err | output | 1 | Strobe: data CRC bad |
| rd_done | output | 1 | Strobe: read run finished |

## Verification
Track bytes and payload bytes pass through with no register stage, so each one belongs to the cycle in which valid and ready are both high. The bench drives inputs just after a rising edge, evaluates the handshake at the falling edge, and compares every transfer against a queue it built from the requirements. The status strobes and the captured identifier change one cycle after the edge that takes the final CRC byte (or the last byte of the window). The strobe monitor counts pulses at falling edges, and the read task compares those counts once `rd_done` has been seen. `wr_busy` drops in the cycle after the last write CRC byte is accepted, and the bench checks it at the next falling edge.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam logic [7:0]  SYNC_NORMAL  = 8'hDB;
    localparam logic [7:0]  SYNC_SPECIAL = 8'hDD;
    localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY     = 16'h1021;
    localparam int          ID_BYTES     = 4;

    typedef enum logic [3:0] {
        TX_IDLE, TX_GAP_A, TX_SYNC_A, TX_IDB, TX_CRC_A,
        TX_GAP_B, TX_SYNC_B, TX_DATA, TX_CRC_B
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_HUNT_ID, RX_IDB, RX_CRC_ID,
        RX_HUNT_DATA, RX_DATA, RX_CRC_DATA
    } rx_state_e;

    // One byte into the CRC register, most significant bit first
    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ b[i]) r = (r << 1) ^ CRC_POLY;
            else              r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/sfr_len_dec.sv
module sfr_len_dec #(
    parameter int BASE_LEN = 128,
    parameter int CW       = 10
) (
    input  logic [1:0]    size_code,
    output logic [CW-1:0] len
);
    logic [1:0] shift;

    always_comb begin
        shift = (size_code[1]) ? 2'd2 : size_code;
        len   = CW'(BASE_LEN) << shift;
    end
endmodule

// File: rtl/sfr_tx.sv
module sfr_tx
    import sfr_pkg::*;
#(
    parameter int GAP_LEN = 15,
    parameter int CW      = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          with_id,
    input  logic          special,
    input  logic [CW-1:0] len,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data,
    output logic          busy
);
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_LEN - 1);
    localparam logic [CW-1:0] ID_LAST  = CW'(ID_BYTES - 1);

    typedef struct packed {
        tx_state_e     st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] len;
        logic [15:0]   crc;
        logic          special;
    } tx_reg_t;

    tx_reg_t q, d;
    logic [7:0] sync_b;

    always_comb begin
        d         = q;
        out_valid = 1'b0;
        out_data  = 8'h00;
        in_ready  = 1'b0;
        sync_b    = q.special ? SYNC_SPECIAL : SYNC_NORMAL;
        case (q.st)
            TX_IDLE: begin
                if (start) begin
                    d.len     = len;
                    d.special = special;
                    d.cnt     = '0;
                    d.st      = with_id ? TX_GAP_A : TX_GAP_B;
                end
            end
            TX_GAP_A, TX_GAP_B: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    if (q.cnt == GAP_LAST) begin
                        d.cnt = '0;
                        d.st  = (q.st == TX_GAP_A) ? TX_SYNC_A : TX_SYNC_B;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            TX_SYNC_A, TX_SYNC_B: begin
                out_valid = 1'b1;
                out_data  = (q.st == TX_SYNC_A) ? SYNC_NORMAL : sync_b;
                if (out_ready) begin
                    d.crc = crc_byte(CRC_PRESET, out_data);
                    d.cnt = '0;
                    d.st  = (q.st == TX_SYNC_A) ? TX_IDB : TX_DATA;
                end
            end
            TX_IDB, TX_DATA: begin
                out_valid = in_valid;
                out_data  = in_data;
                in_ready  = out_ready;
                if (in_valid && out_ready) begin
                    d.crc = crc_byte(q.crc, in_data);
                    if ((q.st == TX_IDB && q.cnt == ID_LAST) ||
                        (q.st == TX_DATA && q.cnt == q.len - CW'(1))) begin
                        d.cnt = '0;
                        d.st  = (q.st == TX_IDB) ? TX_CRC_A : TX_CRC_B;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            TX_CRC_A, TX_CRC_B: begin
                out_valid = 1'b1;
                out_data  = q.cnt[0] ? q.crc[7:0] : q.crc[15:8];
                if (out_ready) begin
                    if (q.cnt[0]) begin
                        d.cnt = '0;
                        d.st  = (q.st == TX_CRC_A) ? TX_GAP_B : TX_IDLE;
                    end else begin
                        d.cnt = CW'(1);
                    end
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = (q.st != TX_IDLE);
endmodule

// File: rtl/sfr_rx.sv
module sfr_rx
    import sfr_pkg::*;
#(
    parameter int GAP_LEN  = 15,
    parameter int SYNC_TOL = 4,
    parameter int CW       = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          with_id,
    input  logic [CW-1:0] len,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data,
    output logic          busy,
    output logic [31:0]   id_bytes,
    output logic          special,
    output logic          id_ok,
    output logic          id_sync_err,
    output logic          id_crc_err,
    output logic          dat_sync_err,
    output logic          dat_crc_err,
    output logic          done
);
    localparam logic [CW-1:0] WIN_LAST = CW'(GAP_LEN + SYNC_TOL - 1);
    localparam logic [CW-1:0] ID_LAST  = CW'(ID_BYTES - 1);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] len;
        logic [15:0]   crc;
        logic [31:0]   id;
        logic          special;
        logic          id_ok;
        logic          id_sync_err;
        logic          id_crc_err;
        logic          dat_sync_err;
        logic          dat_crc_err;
        logic          done;
    } rx_reg_t;

    rx_reg_t q, d;
    logic [15:0] crc_nx;
    logic        is_sync;

    always_comb begin
        d              = q;
        d.id_ok        = 1'b0;
        d.id_sync_err  = 1'b0;
        d.id_crc_err   = 1'b0;
        d.dat_sync_err = 1'b0;
        d.dat_crc_err  = 1'b0;
        d.done         = 1'b0;
        in_ready       = 1'b0;
        out_valid      = 1'b0;
        out_data       = in_data;
        crc_nx         = crc_byte(q.crc, in_data);
        is_sync        = (in_data == SYNC_NORMAL) ||
                         (q.st == RX_HUNT_DATA && in_data == SYNC_SPECIAL);
        case (q.st)
            RX_IDLE: begin
                if (start) begin
                    d.len     = len;
                    d.cnt     = '0;
                    d.special = 1'b0;
                    d.id      = '0;
                    d.st      = with_id ? RX_HUNT_ID : RX_HUNT_DATA;
                end
            end
            RX_HUNT_ID, RX_HUNT_DATA: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (is_sync) begin
                        d.crc = crc_byte(CRC_PRESET, in_data);
                        d.cnt = '0;
                        if (q.st == RX_HUNT_ID) begin
                            d.st = RX_IDB;
                        end else begin
                            d.special = (in_data == SYNC_SPECIAL);
                            d.st      = RX_DATA;
                        end
                    end else if (q.cnt == WIN_LAST) begin
                        d.id_sync_err  = (q.st == RX_HUNT_ID);
                        d.dat_sync_err = (q.st == RX_HUNT_DATA);
                        d.done         = 1'b1;
                        d.st           = RX_IDLE;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            RX_IDB: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.crc = crc_nx;
                    d.id  = {q.id[23:0], in_data};
                    if (q.cnt == ID_LAST) begin
                        d.cnt = '0;
                        d.st  = RX_CRC_ID;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            RX_DATA: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                if (in_valid && out_ready) begin
                    d.crc = crc_nx;
                    if (q.cnt == q.len - CW'(1)) begin
                        d.cnt = '0;
                        d.st  = RX_CRC_DATA;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            RX_CRC_ID, RX_CRC_DATA: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.crc = crc_nx;
                    if (!q.cnt[0]) begin
                        d.cnt = CW'(1);
                    end else begin
                        d.cnt = '0;
                        if (q.st == RX_CRC_ID) begin
                            if (crc_nx == 16'h0000) begin
                                d.id_ok = 1'b1;
                                d.st    = RX_HUNT_DATA;
                            end else begin
                                d.id_crc_err = 1'b1;
                                d.done       = 1'b1;
                                d.st         = RX_IDLE;
                            end
                        end else begin
                            d.dat_crc_err = (crc_nx != 16'h0000);
                            d.done        = 1'b1;
                            d.st          = RX_IDLE;
                        end
                    end
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy         = (q.st != RX_IDLE);
    assign id_bytes     = q.id;
    assign special      = q.special;
    assign id_ok        = q.id_ok;
    assign id_sync_err  = q.id_sync_err;
    assign id_crc_err   = q.id_crc_err;
    assign dat_sync_err = q.dat_sync_err;
    assign dat_crc_err  = q.dat_crc_err;
    assign done         = q.done;
endmodule

// File: rtl/sector_framer.sv
module sector_framer #(
    parameter int BASE_LEN = 128,
    parameter int GAP_LEN  = 15,
    parameter int SYNC_TOL = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_size,
    input  logic       wr_start,
    input  logic       wr_with_id,
    input  logic       wr_special,
    output logic       wr_busy,
    input  logic       wr_in_valid,
    output logic       wr_in_ready,
    input  logic [7:0] wr_in_data,
    output logic       line_out_valid,
    input  logic       line_out_ready,
    output logic [7:0] line_out_data,
    input  logic       rd_start,
    input  logic       rd_with_id,
    output logic       rd_busy,
    input  logic       line_in_valid,
    output logic       line_in_ready,
    input  logic [7:0] line_in_data,
    output logic       rd_out_valid,
    input  logic       rd_out_ready,
    output logic [7:0] rd_out_data,
    output logic [7:0] rd_id_flag,
    output logic [7:0] rd_id_cyl,
    output logic [7:0] rd_id_head,
    output logic [7:0] rd_id_sec,
    output logic       rd_defective,
    output logic       rd_special,
    output logic       rd_id_ok,
    output logic       rd_id_sync_err,
    output logic       rd_id_crc_err,
    output logic       rd_data_sync_err,
    output logic       rd_data_crc_err,
    output logic       rd_done
);
    localparam int MAX_LEN = BASE_LEN * 4;
    localparam int WIN     = GAP_LEN + SYNC_TOL;
    localparam int CW      = $clog2(((MAX_LEN > WIN) ? MAX_LEN : WIN) + 1);

    logic [CW-1:0] sect_len;
    logic [31:0]   id_bytes;

    sfr_len_dec #(.BASE_LEN(BASE_LEN), .CW(CW)) len_i (
        .size_code (cfg_size),
        .len       (sect_len)
    );

    sfr_tx #(.GAP_LEN(GAP_LEN), .CW(CW)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (wr_start),
        .with_id   (wr_with_id),
        .special   (wr_special),
        .len       (sect_len),
        .in_valid  (wr_in_valid),
        .in_ready  (wr_in_ready),
        .in_data   (wr_in_data),
        .out_valid (line_out_valid),
        .out_ready (line_out_ready),
        .out_data  (line_out_data),
        .busy      (wr_busy)
    );

    sfr_rx #(.GAP_LEN(GAP_LEN), .SYNC_TOL(SYNC_TOL), .CW(CW)) rx_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (rd_start),
        .with_id      (rd_with_id),
        .len          (sect_len),
        .in_valid     (line_in_valid),
        .in_ready     (line_in_ready),
        .in_data      (line_in_data),
        .out_valid    (rd_out_valid),
        .out_ready    (rd_out_ready),
        .out_data     (rd_out_data),
        .busy         (rd_busy),
        .id_bytes     (id_bytes),
        .special      (rd_special),
        .id_ok        (rd_id_ok),
        .id_sync_err  (rd_id_sync_err),
        .id_crc_err   (rd_id_crc_err),
        .dat_sync_err (rd_data_sync_err),
        .dat_crc_err  (rd_data_crc_err),
        .done         (rd_done)
    );

    assign rd_id_flag   = id_bytes[31:24];
    assign rd_id_cyl    = id_bytes[23:16];
    assign rd_id_head   = id_bytes[15:8];
    assign rd_id_sec    = id_bytes[7:0];
    assign rd_defective = id_bytes[24];
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_busy,
    input logic wr_in_ready,
    input logic line_out_valid,
    input logic rd_busy,
    input logic line_in_ready,
    input logic rd_out_valid,
    input logic rd_out_ready,
    input logic rd_id_sync_err,
    input logic rd_id_crc_err,
    input logic rd_data_sync_err,
    input logic rd_data_crc_err,
    input logic rd_done
);
    AST_ERR_FINISHES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_id_sync_err || rd_id_crc_err || rd_data_sync_err || rd_data_crc_err) |-> rd_done)
        else $error("error strobe without done"); // R7

    AST_ONE_ERROR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_id_sync_err, rd_id_crc_err, rd_data_sync_err, rd_data_crc_err}))
        else $error("several error strobes at once"); // R10

    AST_DONE_RELEASES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !rd_busy)
        else $error("done while read still busy"); // R8

    AST_BAD_ID_NO_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_id_crc_err |=> !rd_out_valid)
        else $error("payload after identifier CRC error"); // R9

    AST_RD_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out_valid && !rd_out_ready) |-> !line_in_ready)
        else $error("track byte taken while consumer stalled"); // R11

    AST_WR_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_busy |-> (!line_out_valid && !wr_in_ready))
        else $error("write path active while idle"); // R12
endmodule

bind sector_framer sfr_checker chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_busy          (wr_busy),
    .wr_in_ready      (wr_in_ready),
    .line_out_valid   (line_out_valid),
    .rd_busy          (rd_busy),
    .line_in_ready    (line_in_ready),
    .rd_out_valid     (rd_out_valid),
    .rd_out_ready     (rd_out_ready),
    .rd_id_sync_err   (rd_id_sync_err),
    .rd_id_crc_err    (rd_id_crc_err),
    .rd_data_sync_err (rd_data_sync_err),
    .rd_data_crc_err  (rd_data_crc_err),
    .rd_done          (rd_done)
);

// File: tb/sector_framer_tb_top.sv
module sector_framer_tb_top;
    localparam int GAP = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_size = 2'd0;
    logic       wr_start = 1'b0, wr_with_id = 1'b0, wr_special = 1'b0;
    logic       wr_busy, wr_in_ready, line_out_valid;
    logic       wr_in_valid = 1'b0;
    logic [7:0] wr_in_data = 8'h00;
    logic       line_out_ready = 1'b0;
    logic [7:0] line_out_data;
    logic       rd_start = 1'b0, rd_with_id = 1'b0;
    logic       rd_busy, line_in_ready, rd_out_valid;
    logic       line_in_valid = 1'b0;
    logic [7:0] line_in_data = 8'h00;
    logic       rd_out_ready = 1'b0;
    logic [7:0] rd_out_data, rd_id_flag, rd_id_cyl, rd_id_head, rd_id_sec;
    logic       rd_defective, rd_special, rd_id_ok, rd_id_sync_err, rd_id_crc_err;
    logic       rd_data_sync_err, rd_data_crc_err, rd_done;

    always #2 clk = ~clk;

    sector_framer dut_i (.*);

    int checks = 0;
    int errors = 0;
    int n_idok, n_idsync, n_idcrc, n_dsync, n_dcrc, n_done;
    logic [7:0] exp_q[$];
    logic [7:0] rexp_q[$];
    logic [7:0] tape[$];
    logic [7:0] last_frame[$];
    logic [7:0] last_payload[$];
    logic [7:0] fa[$], pa[$], fb[$], pb[$], fc[$], pc[$], t[$], none[$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            logic fbk;
            fbk = r[15] ^ b[7-k];
            r = {r[14:0], 1'b0};
            if (fbk) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic mon_line();
        forever begin
            @(negedge clk);
            if (rst_n && line_out_valid && line_out_ready) begin
                if (exp_q.size() == 0) chk(1'b0, "R1", "unexpected line byte", line_out_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(line_out_data == e, "R1", "line byte", line_out_data, e);
                end
                tape.push_back(line_out_data);
            end
        end
    endtask

    task automatic mon_rd();
        forever begin
            @(negedge clk);
            if (rst_n && rd_out_valid && rd_out_ready) begin
                if (rexp_q.size() == 0) chk(1'b0, "R11", "unexpected payload byte", rd_out_data, 0);
                else begin
                    logic [7:0] e;
                    e = rexp_q.pop_front();
                    chk(rd_out_data == e, "R11", "payload byte", rd_out_data, e);
                end
            end
        end
    endtask

    task automatic mon_flags();
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (rd_id_ok)         n_idok++;
                if (rd_id_sync_err)   n_idsync++;
                if (rd_id_crc_err)    n_idcrc++;
                if (rd_data_sync_err) n_dsync++;
                if (rd_data_crc_err)  n_dcrc++;
                if (rd_done)          n_done++;
            end
        end
    endtask

    task automatic watchdog();
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic run_write(input bit with_id, input bit special, input logic [1:0] size,
                             input logic [7:0] flag, input logic [7:0] cyl, input logic [7:0] head,
                             input logic [7:0] sec, input int seed, input bit poke);
        int len, mark, idx, cyc, flen;
        logic [15:0] c;
        logic [7:0] src[$];
        logic [7:0] frame[$];
        logic [7:0] ids[4];
        bit take;
        len = 128 << ((size >= 2) ? 2 : size);
        ids = '{flag, cyl, head, sec};
        last_payload.delete();
        if (with_id) begin
            repeat (GAP) frame.push_back(8'h00);
            frame.push_back(8'hDB);
            c = bcrc(16'hFFFF, 8'hDB);
            for (int i = 0; i < 4; i++) begin
                frame.push_back(ids[i]); src.push_back(ids[i]); c = bcrc(c, ids[i]);
            end
            frame.push_back(c[15:8]); frame.push_back(c[7:0]);
        end
        repeat (GAP) frame.push_back(8'h00);
        frame.push_back(special ? 8'hDD : 8'hDB);
        c = bcrc(16'hFFFF, special ? 8'hDD : 8'hDB);
        for (int i = 0; i < len; i++) begin
            logic [7:0] p;
            p = 8'(seed * 13 + i * 7) ^ 8'(i >> 3);
            frame.push_back(p); src.push_back(p); last_payload.push_back(p); c = bcrc(c, p);
        end
        frame.push_back(c[15:8]); frame.push_back(c[7:0]);
        foreach (frame[i]) exp_q.push_back(frame[i]);
        mark = tape.size();
        @(posedge clk); #1;
        cfg_size = size; wr_with_id = with_id; wr_special = special; wr_start = 1'b1;
        @(posedge clk); #1;
        wr_start = 1'b0; cfg_size = ~size;
        idx = 0; cyc = 0;
        while (exp_q.size() != 0) begin
            wr_in_valid = (idx < src.size()) && (cyc % 5 != 4);
            wr_in_data = (idx < src.size()) ? src[idx] : 8'h00;
            line_out_ready = (cyc % 4 != 3);
            if (poke && (cyc == 40 || cyc == 41)) begin
                wr_start = 1'b1; wr_with_id = ~with_id; wr_special = ~special; cfg_size = 2'd0;
            end else wr_start = 1'b0;
            @(negedge clk);
            take = wr_in_valid && wr_in_ready;
            @(posedge clk); #1;
            if (take) idx++;
            cyc++;
        end
        wr_in_valid = 1'b0; wr_start = 1'b0; line_out_ready = 1'b0;
        @(negedge clk);
        chk(!wr_busy, "R1", "busy after last CRC byte", wr_busy, 0);
        chk(idx == src.size(), "R1", "host bytes consumed", idx, src.size());
        last_frame.delete();
        for (int i = mark; i < tape.size(); i++) last_frame.push_back(tape[i]);
        flen = (with_id ? GAP + 7 : 0) + GAP + 1 + len + 2;
        chk(last_frame.size() == flen, with_id ? "R5" : "R4", "frame length", last_frame.size(), flen);
        if (poke) begin
            int bad;
            bad = 0;
            foreach (frame[i]) if (i >= last_frame.size() || last_frame[i] != frame[i]) bad++;
            chk(bad == 0, "R12", "frame disturbed by start while busy", bad, 0);
        end
        begin
            int ds;
            logic [15:0] r;
            ds = with_id ? GAP + 7 + GAP : GAP;
            chk(last_frame[ds] == (special ? 8'hDD : 8'hDB), "R3", "data sync byte",
                last_frame[ds], special ? 8'hDD : 8'hDB);
            r = 16'hFFFF;
            for (int i = ds; i < last_frame.size(); i++) r = bcrc(r, last_frame[i]);
            chk(r == 16'h0000, "R2", "data field CRC remainder", r, 0);
        end
    endtask

    task automatic run_read(input bit with_id, input logic [7:0] tp[$], input logic [7:0] pay[$],
                            input logic [1:0] size, input int kind, input bit exp_special,
                            input logic [7:0] flag, input logic [7:0] cyl, input logic [7:0] head,
                            input logic [7:0] sec);
        int idx, cyc;
        bit take;
        rexp_q = pay;
        n_idok = 0; n_idsync = 0; n_idcrc = 0; n_dsync = 0; n_dcrc = 0; n_done = 0;
        @(posedge clk); #1;
        cfg_size = size; rd_with_id = with_id; rd_start = 1'b1;
        @(posedge clk); #1;
        rd_start = 1'b0; cfg_size = ~size;
        idx = 0; cyc = 0;
        while (n_done == 0) begin
            line_in_valid = (idx < tp.size());
            line_in_data = (idx < tp.size()) ? tp[idx] : 8'h00;
            rd_out_ready = (cyc % 3 != 2);
            @(negedge clk);
            take = line_in_valid && line_in_ready;
            @(posedge clk); #1;
            if (take) idx++;
            cyc++;
        end
        line_in_valid = 1'b0; rd_out_ready = 1'b0;
        @(negedge clk);
        chk(n_done == 1, "R7", "done pulses", n_done, 1);
        chk(n_idsync == (kind == 1 ? 1 : 0), "R7", "identifier sync error", n_idsync, kind == 1);
        chk(n_idcrc == (kind == 2 ? 1 : 0), "R9", "identifier CRC error", n_idcrc, kind == 2);
        chk(n_dsync == (kind == 3 ? 1 : 0), "R8", "data sync error", n_dsync, kind == 3);
        chk(n_dcrc == (kind == 4 ? 1 : 0), "R10", "data CRC error", n_dcrc, kind == 4);
        chk(n_idok == ((with_id && kind != 1 && kind != 2) ? 1 : 0), "R6", "identifier ok",
            n_idok, with_id && kind != 1 && kind != 2);
        chk(rexp_q.size() == 0, "R11", "payload bytes left over", rexp_q.size(), 0);
        if (kind == 0 || kind == 4)
            chk(rd_special == exp_special, "R3", "special flag", rd_special, exp_special);
        if (with_id && (kind == 0 || kind == 3 || kind == 4)) begin
            chk({rd_id_flag, rd_id_cyl, rd_id_head, rd_id_sec} == {flag, cyl, head, sec}, "R6",
                "identifier bytes", {rd_id_flag, rd_id_cyl, rd_id_head, rd_id_sec}, {flag, cyl, head, sec});
            chk(rd_defective == flag[0], "R6", "defective flag", rd_defective, flag[0]);
        end
    endtask

    initial begin
        fork
            mon_line();
            mon_rd();
            mon_flags();
            watchdog();
        join_none
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!wr_busy && !rd_busy, "R12", "busy in reset", {wr_busy, rd_busy}, 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!line_out_valid && !wr_in_ready, "R12", "write idle quiet", {line_out_valid, wr_in_ready}, 0);
        chk(!rd_out_valid && !rd_done, "R11", "read idle quiet", {rd_out_valid, rd_done}, 0);

        // normal sector with identifier, 128-byte payload, defective flag set
        run_write(1'b1, 1'b0, 2'd0, 8'h01, 8'h4C, 8'h02, 8'h1F, 3, 1'b0);
        fa = last_frame; pa = last_payload;
        run_read(1'b1, fa, pa, 2'd0, 0, 1'b0, 8'h01, 8'h4C, 8'h02, 8'h1F);

        // data-only special sector, 256 bytes, start pulsed while busy
        run_write(1'b0, 1'b1, 2'd1, 8'h00, 8'h00, 8'h00, 8'h00, 9, 1'b1);
        fb = last_frame; pb = last_payload;
        run_read(1'b0, fb, pb, 2'd1, 0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00);

        // size code 3 selects 512 bytes; flag without bit 0
        run_write(1'b1, 1'b0, 2'd3, 8'h80, 8'hC8, 8'h03, 8'h00, 21, 1'b0);
        fc = last_frame; pc = last_payload;
        run_read(1'b1, fc, pc, 2'd3, 0, 1'b0, 8'h80, 8'hC8, 8'h03, 8'h00);

        // R9: corrupted cylinder byte
        t = fa; t[GAP + 2] = t[GAP + 2] ^ 8'h40;
        run_read(1'b1, t, none, 2'd0, 2, 1'b0, 8'h01, 8'h4C, 8'h02, 8'h1F);

        // R10: corrupted payload byte, delivered as read
        t = fa; t[GAP + 7 + GAP + 1 + 10] = t[GAP + 7 + GAP + 1 + 10] ^ 8'h01;
        rexp_q.delete();
        begin
            logic [7:0] pm[$];
            pm = pa; pm[10] = pm[10] ^ 8'h01;
            run_read(1'b1, t, pm, 2'd0, 4, 1'b0, 8'h01, 8'h4C, 8'h02, 8'h1F);
        end

        // R7: sync at the last position of the window is still accepted
        t = fa; t.push_front(8'h00); t.push_front(8'h00); t.push_front(8'hDD);
        run_read(1'b1, t, pa, 2'd0, 0, 1'b0, 8'h01, 8'h4C, 8'h02, 8'h1F);

        // R7: one byte later is outside the window
        t = fa; repeat (4) t.push_front(8'h00);
        run_read(1'b1, t, none, 2'd0, 1, 1'b0, 8'h01, 8'h4C, 8'h02, 8'h1F);

        // R8: data sync pushed past the window after a good identifier
        t = fa; repeat (4) t.insert(GAP + 7, 8'h00);
        run_read(1'b1, t, none, 2'd0, 3, 1'b0, 8'h01, 8'h4C, 8'h02, 8'h1F);

        // R8: data-only read with late sync
        t = fb; repeat (4) t.push_front(8'h00);
        run_read(1'b0, t, none, 2'd1, 3, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00);

        repeat (4) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule